// File: doc/BRIEF.md
# PCIe Bridge Power-State Controller

This block keeps the device power-management state for a switch with one upstream bridge (port 0) and several downstream bridges. Software changes a port's power state by writing the PowerState field of that bridge's power control register, and brings a freshly reset port into service by setting its command enables. The block turns those writes, together with main-power, auxiliary-power and link-state reports, into one effective state per port. It also produces a per-port permission for the link to enter L1, a one-cycle context-reset pulse, and the wake outputs (an in-band beacon request per port and a shared active-low sideband wake pin).

Configuration writes reach the block on a valid/ready channel. A write completes on a clock edge where `cfg_wr_valid` and `cfg_wr_ready` are both high. `cfg_wr_ready` depends only on `cfg_wr_port`. It is low while the addressed port is counting its D3hot recovery delay. The source must hold the write unchanged until it is taken. Writes to other ports are not held up.

Top module: `pm_state_ctrl`

## Requirements
- R1: Reset state. After reset, every port is in D0 Uninitialized and every PowerState field reads 00. `l1_allowed` and `beacon_req` are all low, `wake_n` is high and `cfg_wr_ready` is high. The effective-state code is 00 for D0 Uninitialized, 01 for D0 Active, 10 for D3hot and 11 for D3cold.
- R2: A command write (`cfg_wr_sel`=0) to a port in D0 Uninitialized moves that port to D0 Active on the next edge if any of data bits [2:0] (I/O, memory and bus-master enables) is set. A command write with all three bits clear leaves the state unchanged.
- R3: A PowerState write (`cfg_wr_sel`=1, data[1:0]=11) to a port in D0 moves it to D3hot on the next edge. `l1_allowed[i]` is high exactly when port i's effective state is D3hot.
- R4: A PowerState write of 00 to a port in D3hot takes effect RECOV_CYC edges after the accepting edge. The state stays D3hot until then. During the delay, `cfg_wr_ready` is low for that port and stays high for the other ports.
- R5: The read-only no-soft-reset bit is the parameter NO_SOFT_RST. When it is 1, leaving D3hot lands in D0 Active with no context reset. When it is 0, leaving D3hot lands in D0 Uninitialized and pulses `ctx_reset` for that port.
- R6: When `link_l23_ready[i]` is high at an edge, port i returns to D0 Uninitialized, its PowerState field becomes 00 and `ctx_reset[i]` pulses, regardless of NO_SOFT_RST. When this happens on port 0, it resets every port.
- R7: While the upstream port is in D3hot or D3cold, the effective state of every downstream port equals the upstream state. A downstream port's own PowerState field is not changed by this.
- R8: When main power is lost (`main_pwr_good`=0), a port in D3hot moves to D3cold on the next edge, and ports in D0 are not affected. When main power returns, a port in D3cold moves to D0 Uninitialized with its field at 00 and pulses `ctx_reset`.
- R9: PowerState writes with data[1:0] of 01 or 10 are ignored: the field and the state keep their old values.
- R10: When `pme_event[i]` is high and port i's effective state is D3hot or D3cold, then one edge later `beacon_req[i]` is high and `wake_n` is low, but only if `aux_pwr_ok` was high. Otherwise both stay inactive.
- R11: A write to a port in D3cold is accepted (ready high) and then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| cfg_wr_valid | input | 1 | Configuration write offered |
| cfg_wr_ready | output | 1 | Write can be taken for the addressed port |
| cfg_wr_port | input | $clog2(NUM_PORTS) | Target bridge, 0 = upstream |
| cfg_wr_sel | input | 1 | 1 = power control register, 0 = command enables |
| cfg_wr_data | input | 3 | [1:0] PowerState, or [2:0] command enables |
| main_pwr_good | input | 1 | Main supply present |
| aux_pwr_ok | input | 1 | Auxiliary supply present |
| link_l23_ready | input | NUM_PORTS | Link of port i reached L2/L3 Ready |
| pme_event | input | NUM_PORTS | Port i requests a wakeup |
| eff_state | output | 2*NUM_PORTS | Effective state per port, 2 bits each |
| pmcsr_ps | output | 2*NUM_PORTS | Own PowerState field per port |
| l1_allowed | output | NUM_PORTS | Link of port i may enter L1 |
| ctx_reset | output | NUM_PORTS | One-cycle context reset pulse |
| beacon_req | output | NUM_PORTS | In-band beacon request |
| wake_n | output | 1 | Sideband wake, active low |

## Verification
The bench counts the recovery delay cycle by cycle. A design that switched early, or that let ready rise before the delay ends, fails at the exact cycle where it does so. It builds a second copy with the no-soft-reset bit cleared and checks both copies across the same D3hot exit and the same L2/L3 Ready. A design that ignored the bit, or that kept context after L2/L3 Ready, shows the wrong state or no reset pulse. The bench also checks the upstream override, the ignored 01/10 encodings, and writes dropped in D3cold. A design that leaked the override into a downstream field, latched a reserved encoding, or woke without auxiliary power shows a changed field or an early wake pin.

// File: rtl/pm_state_ctrl_pkg.sv
package pm_state_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_D0_UNINIT = 2'b00,
    ST_D0_ACTIVE = 2'b01,
    ST_D3_HOT    = 2'b10,
    ST_D3_COLD   = 2'b11
  } pm_state_e;

  localparam logic [1:0] PS_FIELD_D0 = 2'b00;
  localparam logic [1:0] PS_FIELD_D3 = 2'b11;

  function automatic logic in_d3(input pm_state_e s);
    return (s == ST_D3_HOT) || (s == ST_D3_COLD);
  endfunction

endpackage

// File: rtl/pm_port_fsm.sv
module pm_port_fsm
  import pm_state_ctrl_pkg::*;
#(
  parameter int RECOV_CYC   = 8,
  parameter bit NO_SOFT_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_pm,
  input  logic       wr_cmd,
  input  logic [2:0] wr_data,
  input  logic       main_pwr_good,
  input  logic       link_reset,
  output pm_state_e  state,
  output logic [1:0] ps_field,
  output logic       busy,
  output logic       ctx_reset
);

  localparam int CW = $clog2(RECOV_CYC + 1);

  logic [CW-1:0] recov_cnt;

  assign busy = (recov_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_D0_UNINIT;
      ps_field  <= PS_FIELD_D0;
      recov_cnt <= '0;
      ctx_reset <= 1'b0;
    end else begin
      ctx_reset <= 1'b0;
      if (link_reset) begin
        // link reached L2/L3 Ready: full reset, soft-reset bit has no say
        state     <= ST_D0_UNINIT;
        ps_field  <= PS_FIELD_D0;
        recov_cnt <= '0;
        ctx_reset <= 1'b1;
      end else if (state == ST_D3_COLD) begin
        // writes are dropped here; only power return leaves this state
        if (main_pwr_good) begin
          state     <= ST_D0_UNINIT;
          ps_field  <= PS_FIELD_D0;
          ctx_reset <= 1'b1;
        end
      end else if (state == ST_D3_HOT && !main_pwr_good) begin
        state     <= ST_D3_COLD;
        recov_cnt <= '0;
      end else if (busy) begin
        recov_cnt <= recov_cnt - 1'b1;
        if (recov_cnt == CW'(1)) begin
          if (NO_SOFT_RST) begin
            state <= ST_D0_ACTIVE;
          end else begin
            state     <= ST_D0_UNINIT;
            ctx_reset <= 1'b1;
          end
        end
      end else begin
        if (wr_pm) begin
          if (wr_data[1:0] == PS_FIELD_D0 && state == ST_D3_HOT) begin
            ps_field  <= PS_FIELD_D0;
            recov_cnt <= CW'(RECOV_CYC);
          end else if (wr_data[1:0] == PS_FIELD_D3 && state != ST_D3_HOT) begin
            ps_field <= PS_FIELD_D3;
            state    <= ST_D3_HOT;
          end
        end
        if (wr_cmd && state == ST_D0_UNINIT && (|wr_data)) begin
          state <= ST_D0_ACTIVE;
        end
      end
    end
  end

endmodule

// File: rtl/pm_eff_merge.sv
module pm_eff_merge
  import pm_state_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  pm_state_e             own_state [NUM_PORTS],
  output logic [2*NUM_PORTS-1:0] eff_flat,
  output logic [NUM_PORTS-1:0]   l1_ok
);

  pm_state_e eff [NUM_PORTS];

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      if (i == 0) begin : g_up
        assign eff[i] = own_state[0];
      end else begin : g_down
        // the upstream bridge governs the whole device while it sleeps
        assign eff[i] = in_d3(own_state[0]) ? own_state[0] : own_state[i];
      end
      assign eff_flat[2*i +: 2] = eff[i];
      assign l1_ok[i]           = (eff[i] == ST_D3_HOT);
    end
  endgenerate

endmodule

// File: rtl/pm_wake_gen.sv
module pm_wake_gen #(
  parameter int NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   aux_pwr_ok,
  input  logic [NUM_PORTS-1:0]   pme_event,
  input  logic [2*NUM_PORTS-1:0] eff_flat,
  output logic [NUM_PORTS-1:0]   beacon_req,
  output logic                   wake_n
);

  logic [NUM_PORTS-1:0] want;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_want
      // high bit of the state code marks both D3 flavours
      assign want[i] = pme_event[i] && eff_flat[2*i+1] && aux_pwr_ok;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beacon_req <= '0;
      wake_n     <= 1'b1;
    end else begin
      beacon_req <= want;
      wake_n     <= ~(|want);
    end
  end

endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_state_ctrl_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int RECOV_CYC   = 8,
  parameter bit NO_SOFT_RST = 1'b1,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr_valid,
  output logic                   cfg_wr_ready,
  input  logic [PW-1:0]          cfg_wr_port,
  input  logic                   cfg_wr_sel,
  input  logic [2:0]             cfg_wr_data,
  input  logic                   main_pwr_good,
  input  logic                   aux_pwr_ok,
  input  logic [NUM_PORTS-1:0]   link_l23_ready,
  input  logic [NUM_PORTS-1:0]   pme_event,
  output logic [2*NUM_PORTS-1:0] eff_state,
  output logic [2*NUM_PORTS-1:0] pmcsr_ps,
  output logic [NUM_PORTS-1:0]   l1_allowed,
  output logic [NUM_PORTS-1:0]   ctx_reset,
  output logic [NUM_PORTS-1:0]   beacon_req,
  output logic                   wake_n
);

  pm_state_e            own_state [NUM_PORTS];
  logic [NUM_PORTS-1:0] busy;
  logic [NUM_PORTS-1:0] hit;
  logic                 take;

  always_comb begin
    cfg_wr_ready = 1'b1;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (cfg_wr_port == PW'(i) && busy[i]) cfg_wr_ready = 1'b0;
    end
  end

  assign take = cfg_wr_valid && cfg_wr_ready;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_fsm
      assign hit[i] = take && (cfg_wr_port == PW'(i));

      pm_port_fsm #(
        .RECOV_CYC  (RECOV_CYC),
        .NO_SOFT_RST(NO_SOFT_RST)
      ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_pm        (hit[i] && cfg_wr_sel),
        .wr_cmd       (hit[i] && !cfg_wr_sel),
        .wr_data      (cfg_wr_data),
        .main_pwr_good(main_pwr_good),
        .link_reset   (link_l23_ready[i] || link_l23_ready[0]),
        .state        (own_state[i]),
        .ps_field     (pmcsr_ps[2*i +: 2]),
        .busy         (busy[i]),
        .ctx_reset    (ctx_reset[i])
      );
    end
  endgenerate

  pm_eff_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
    .own_state(own_state),
    .eff_flat (eff_state),
    .l1_ok    (l1_allowed)
  );

  pm_wake_gen #(.NUM_PORTS(NUM_PORTS)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .aux_pwr_ok(aux_pwr_ok),
    .pme_event (pme_event),
    .eff_flat  (eff_state),
    .beacon_req(beacon_req),
    .wake_n    (wake_n)
  );

endmodule

// File: rtl/pm_state_ctrl_chk.sv
module pm_state_ctrl_chk #(
  parameter int NUM_PORTS = 4,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr_valid,
  input logic                   cfg_wr_ready,
  input logic [PW-1:0]          cfg_wr_port,
  input logic                   cfg_wr_sel,
  input logic [2:0]             cfg_wr_data,
  input logic                   main_pwr_good,
  input logic                   aux_pwr_ok,
  input logic [NUM_PORTS-1:0]   link_l23_ready,
  input logic [2*NUM_PORTS-1:0] eff_state,
  input logic [2*NUM_PORTS-1:0] pmcsr_ps,
  input logic [NUM_PORTS-1:0]   ctx_reset,
  input logic [NUM_PORTS-1:0]   beacon_req,
  input logic                   wake_n
);

  // R10: the wake pin only drops after a cycle with auxiliary power
  p_wake_aux_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !wake_n |-> $past(aux_pwr_ok));

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
      // R6: L2/L3 Ready clears the port's field on the next edge
      p_l23_clears_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        link_l23_ready[i] |=> (pmcsr_ps[2*i +: 2] == 2'b00));

      // R6: a context reset always leaves the field at D0
      p_ctx_clean_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        ctx_reset[i] |-> (pmcsr_ps[2*i +: 2] == 2'b00));

      // R9: reserved encodings leave the field as it was
      p_bad_enc_ignored_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_valid && cfg_wr_ready && cfg_wr_sel && cfg_wr_port == PW'(i) &&
         (cfg_wr_data[1:0] == 2'b01 || cfg_wr_data[1:0] == 2'b10) &&
         !link_l23_ready[i] && !link_l23_ready[0] && $stable(main_pwr_good))
        |=> $stable(pmcsr_ps[2*i +: 2]));

      // R10: a beacon follows a cycle in which the port was in D3
      p_beacon_d3_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        beacon_req[i] |-> $past(eff_state[2*i+1]));
    end
  endgenerate

endmodule

bind pm_state_ctrl pm_state_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_pm_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr_valid  (cfg_wr_valid),
  .cfg_wr_ready  (cfg_wr_ready),
  .cfg_wr_port   (cfg_wr_port),
  .cfg_wr_sel    (cfg_wr_sel),
  .cfg_wr_data   (cfg_wr_data),
  .main_pwr_good (main_pwr_good),
  .aux_pwr_ok    (aux_pwr_ok),
  .link_l23_ready(link_l23_ready),
  .eff_state     (eff_state),
  .pmcsr_ps      (pmcsr_ps),
  .ctx_reset     (ctx_reset),
  .beacon_req    (beacon_req),
  .wake_n        (wake_n)
);

// File: tb/test_pm_state_ctrl.sv
module test_pm_state_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;
  localparam int RECOV      = 8;
  localparam int PW         = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_valid = 1'b0;
  logic [PW-1:0] cfg_wr_port = '0;
  logic          cfg_wr_sel = 1'b0;
  logic [2:0]    cfg_wr_data = '0;
  logic          main_pwr_good = 1'b1;
  logic          aux_pwr_ok = 1'b0;
  logic [NP-1:0] link_l23_ready = '0;
  logic [NP-1:0] pme_event = '0;

  logic          cfg_wr_ready, cfg_wr_ready_h;
  logic [2*NP-1:0] eff_state, pmcsr_ps, eff_h, ps_h;
  logic [NP-1:0] l1_allowed, ctx_reset, beacon_req;
  logic [NP-1:0] l1_h, ctx_h, beacon_h;
  logic          wake_n, wake_n_h;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_state_ctrl #(.NUM_PORTS(NP), .RECOV_CYC(RECOV), .NO_SOFT_RST(1'b1)) i_pm_state_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready),
    .cfg_wr_port(cfg_wr_port), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .main_pwr_good(main_pwr_good), .aux_pwr_ok(aux_pwr_ok), .link_l23_ready(link_l23_ready),
    .pme_event(pme_event), .eff_state(eff_state), .pmcsr_ps(pmcsr_ps), .l1_allowed(l1_allowed),
    .ctx_reset(ctx_reset), .beacon_req(beacon_req), .wake_n(wake_n));

  pm_state_ctrl #(.NUM_PORTS(NP), .RECOV_CYC(RECOV), .NO_SOFT_RST(1'b0)) i_pm_state_ctrl_hard (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready_h),
    .cfg_wr_port(cfg_wr_port), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .main_pwr_good(main_pwr_good), .aux_pwr_ok(aux_pwr_ok), .link_l23_ready(link_l23_ready),
    .pme_event(pme_event), .eff_state(eff_h), .pmcsr_ps(ps_h), .l1_allowed(l1_h),
    .ctx_reset(ctx_h), .beacon_req(beacon_h), .wake_n(wake_n_h));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int p);
    return int'(eff_state[2*p +: 2]);
  endfunction

  function automatic int effh(input int p);
    return int'(eff_h[2*p +: 2]);
  endfunction

  function automatic int ps(input int p);
    return int'(pmcsr_ps[2*p +: 2]);
  endfunction

  // drive at a falling edge, hold until taken; returns at the falling edge after the taking edge
  task automatic do_wr(input int p, input logic sel, input logic [2:0] d);
    cfg_wr_port  = p[PW-1:0];
    cfg_wr_sel   = sel;
    cfg_wr_data  = d;
    cfg_wr_valid = 1'b1;
    #1;
    while (!cfg_wr_ready) @(negedge clk);
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int p = 0; p < NP; p++) begin
      chk("R1", "eff after reset", eff(p), 0);
      chk("R1", "field after reset", ps(p), 0);
    end
    chk("R1", "l1", int'(l1_allowed), 0);
    chk("R1", "beacon", int'(beacon_req), 0);
    chk("R1", "wake_n", int'(wake_n), 1);
    chk("R1", "ready", int'(cfg_wr_ready), 1);
  endtask

  task automatic t_enable;
    do_wr(1, 1'b0, 3'b000);
    chk("R2", "zero enables keep D0U", eff(1), 0);
    do_wr(1, 1'b0, 3'b010);
    chk("R2", "memory enable -> D0 Active", eff(1), 1);
    do_wr(0, 1'b0, 3'b001);
    do_wr(2, 1'b0, 3'b100);
    do_wr(3, 1'b0, 3'b001);
    chk("R2", "port0 active", eff(0), 1);
    chk("R2", "port2 active", eff(2), 1);
    chk("R2", "port3 active", eff(3), 1);
  endtask

  task automatic t_d3hot;
    do_wr(2, 1'b1, 3'b011);
    chk("R3", "port2 D3hot", eff(2), 2);
    chk("R3", "field 11", ps(2), 3);
    chk("R3", "l1 on D3hot port", int'(l1_allowed[2]), 1);
    chk("R3", "l1 off D0 port", int'(l1_allowed[1]), 0);
  endtask

  task automatic t_recover;
    do_wr(2, 1'b1, 3'b000);
    for (int j = 0; j < RECOV; j++) begin
      if (j > 0) @(negedge clk);
      chk("R4", "still D3hot in delay", eff(2), 2);
      cfg_wr_port = 2'd2; #1;
      chk("R4", "ready low for recovering port", int'(cfg_wr_ready), 0);
      cfg_wr_port = 2'd1; #1;
      chk("R4", "ready high for other port", int'(cfg_wr_ready), 1);
    end
    @(negedge clk);
    chk("R5", "NSR=1 returns D0 Active", eff(2), 1);
    chk("R5", "NSR=1 no ctx reset", int'(ctx_reset[2]), 0);
    chk("R5", "NSR=0 returns D0U", effh(2), 0);
    chk("R5", "NSR=0 ctx reset pulse", int'(ctx_h[2]), 1);
    cfg_wr_port = 2'd2; #1;
    chk("R4", "ready back after delay", int'(cfg_wr_ready), 1);
  endtask

  task automatic t_bad_enc;
    do_wr(1, 1'b1, 3'b001);
    chk("R9", "01 ignored field", ps(1), 0);
    chk("R9", "01 ignored state", eff(1), 1);
    do_wr(1, 1'b1, 3'b010);
    chk("R9", "10 ignored field", ps(1), 0);
    do_wr(1, 1'b1, 3'b011);
    do_wr(1, 1'b1, 3'b010);
    chk("R9", "10 ignored in D3hot", ps(1), 3);
    chk("R9", "state stays D3hot", eff(1), 2);
    do_wr(1, 1'b1, 3'b000);
    repeat (RECOV) @(negedge clk);
    chk("R9", "port1 back active", eff(1), 1);
  endtask

  task automatic t_override;
    do_wr(0, 1'b1, 3'b011);
    chk("R7", "upstream D3hot", eff(0), 2);
    chk("R7", "port1 follows upstream", eff(1), 2);
    chk("R7", "port3 follows upstream", eff(3), 2);
    chk("R7", "port1 field untouched", ps(1), 0);
    chk("R3", "l1 via override", int'(l1_allowed[1]), 1);
    do_wr(0, 1'b1, 3'b000);
    repeat (RECOV) @(negedge clk);
    chk("R7", "port1 own state again", eff(1), 1);
  endtask

  task automatic t_wake;
    do_wr(3, 1'b1, 3'b011);
    aux_pwr_ok = 1'b0;
    pme_event  = 4'b1010;
    repeat (2) @(negedge clk);
    chk("R10", "no wake without aux", int'(wake_n), 1);
    chk("R10", "no beacon without aux", int'(beacon_req), 0);
    aux_pwr_ok = 1'b1;
    @(negedge clk);
    chk("R10", "wake pin low", int'(wake_n), 0);
    chk("R10", "beacon only on D3 port", int'(beacon_req), 8);
    pme_event = 4'b0010;
    @(negedge clk);
    chk("R10", "D0 port does not wake", int'(wake_n), 1);
    pme_event = '0;
  endtask

  task automatic t_cold;
    main_pwr_good = 1'b0;
    @(negedge clk);
    chk("R8", "D3hot -> D3cold", eff(3), 3);
    chk("R8", "D0 port unaffected", eff(1), 1);
    do_wr(3, 1'b1, 3'b000);
    chk("R11", "write in D3cold dropped", ps(3), 3);
    chk("R11", "still D3cold", eff(3), 3);
    cfg_wr_port = 2'd3; #1;
    chk("R11", "ready high in D3cold", int'(cfg_wr_ready), 1);
    main_pwr_good = 1'b1;
    @(negedge clk);
    chk("R8", "power return -> D0U", eff(3), 0);
    chk("R8", "power return ctx pulse", int'(ctx_reset[3]), 1);
    chk("R8", "field reset", ps(3), 0);
  endtask

  task automatic t_l23;
    do_wr(1, 1'b1, 3'b011);
    link_l23_ready[1] = 1'b1;
    @(negedge clk);
    link_l23_ready[1] = 1'b0;
    chk("R6", "L2/L3 -> D0U", eff(1), 0);
    chk("R6", "L2/L3 field 00", ps(1), 0);
    chk("R6", "L2/L3 ctx pulse NSR=1", int'(ctx_reset[1]), 1);
    chk("R6", "L2/L3 ctx pulse NSR=0", int'(ctx_h[1]), 1);
    chk("R6", "other port kept", eff(2), 1);
    do_wr(1, 1'b0, 3'b001);
    link_l23_ready[0] = 1'b1;
    @(negedge clk);
    link_l23_ready[0] = 1'b0;
    for (int p = 0; p < NP; p++) begin
      chk("R6", "upstream L2/L3 resets all", eff(p), 0);
      chk("R6", "upstream L2/L3 resets all NSR=0", effh(p), 0);
    end
    chk("R6", "all ctx pulses", int'(ctx_reset), 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_d3hot();
    t_recover();
    t_bad_enc();
    t_override();
    t_wake();
    t_cold();
    t_l23();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule